// File: doc/BRIEF.md
# Bus-master disk DMA channel register block

This block is the host-facing control and status window of one bus-master DMA channel for a disk interface. It occupies eight bytes of register space. The host uses it to program the base address of the descriptor table, choose the transfer direction, and start or stop a transfer. It also reads back the channel state and clears the completion and fault flags. A separate engine, not part of this block, walks the descriptor table and moves the data. It reports back to this block with single-cycle completion and fault pulses.

The channel state has four parts: an active flag, a sticky fault flag, a sticky completion flag, and two host-owned flags that record whether each of the two drives may use DMA. An interrupt output follows the completion flag. A second output gives the standard pass judgement for a finished transfer. The judgement passes only when the completion flag is set, the fault flag is clear, and the channel is idle.

The host bus is 32 bits wide with byte enables. `reg_sel` = 0 selects the dword that holds offsets 0 to 3, and `reg_sel` = 1 selects the dword at offset 4. Byte lane k of the selected dword is offset (4·sel + k), on data bits [8k+7:8k]. Reads are combinational from the stored state.

Top module: `bmdma_ctrl`

## Requirements
- R1: While `rst_n` is low, every register reads zero, and `irq`, `eng_run`, `eng_to_mem`, `xfer_good` and `eng_table_base` are zero.
- R2: A write to offset 0 (lane 0, `reg_sel` = 0) with bit 0 = 1 while the channel is idle sets the active flag (status bit 0) and `eng_run` on the following cycle. Offset 0 bit 0 then reads 1.
- R3: A write to offset 0 with bit 0 = 1 while the channel is active is ignored completely. The active flag, offset 0 bit 0 and the direction bit all keep their values.
- R4: A write to offset 0 with bit 0 = 0 stops the channel: the active flag and offset 0 bit 0 read 0 on the next cycle. Such a write also loads the direction bit.
- R5: Offset 0 bit 3 is the direction bit. A value of 1 means data moves from the device to memory, and `eng_to_mem` follows the stored bit. All other bits of offset 0, except bit 0, read 0.
- R6: An `eng_done` pulse while active clears the active flag and sets the completion flag (status bit 2). Engine pulses that arrive while idle have no effect.
- R7: An `eng_err` pulse while active sets the fault flag (status bit 1) and the completion flag and clears the active flag. This also holds when `eng_done` arrives in the same cycle.
- R8: At offset 2 (lane 2), a 1 written to bit 1 or bit 2 clears that flag, and a 0 leaves it unchanged. If an engine pulse sets a flag in the same cycle as the host clears it, the set wins.
- R9: Offset 2 bits 5 and 6 are read/write per-drive DMA-capable flags for drive 0 and drive 1. They change only on a write to lane 2. Status bits 3, 4 and 7 always read 0.
- R10: Offsets 4 to 7 (`reg_sel` = 1) hold the descriptor table base, written per byte lane. Bits 1:0 always read 0. `eng_table_base` equals the stored value.
- R11: Offsets 1 and 3 are free read/write scratch bytes. Byte lanes whose enable is low keep their contents.
- R12: `irq` equals status bit 2 at all times.
- R13: `xfer_good` is 1 exactly when status bits 2:0 read 100b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Dword select: 0 = offsets 0-3, 1 = offsets 4-7 |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_be | input | 4 | Byte-lane enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected dword |
| eng_run | output | 1 | Active flag driven to the engine |
| eng_to_mem | output | 1 | Direction to the engine, 1 = device to memory |
| eng_table_base | output | 32 | Descriptor table base, dword aligned |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine fault pulse |
| irq | output | 1 | Interrupt, mirrors the completion flag |
| xfer_good | output | 1 | Transfer finished cleanly |

## Verification
The properties assume several things about the inputs. Engine pulses last one cycle and appear only while `eng_run` is high, unless a test deliberately probes the idle-ignore rule. Host writes never carry unknown values, and the byte enables only select lanes that exist. The stimulus drives every input on the falling clock edge and returns the write strobe and the engine pulses to zero after a single cycle. The idle-time pulse is applied only where R6 asks for it, and even then the properties stay true, because they are conditioned on `eng_run`.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    // Bus geometry
    localparam int REG_W   = 32;
    localparam int BYTE_W  = 8;
    localparam int LANES   = REG_W / BYTE_W;
    localparam int ALIGN_W = 2;

    // Byte lanes inside the low dword
    localparam int LANE_CMD  = 0;
    localparam int LANE_SCR1 = 1;
    localparam int LANE_STAT = 2;
    localparam int LANE_SCR3 = 3;

    // Command byte bit positions
    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;

    // Status byte bit positions
    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_IRQ  = 2;
    localparam int ST_CAP0 = 5;
    localparam int ST_CAP1 = 6;

    typedef struct packed {
        logic              start;
        logic              to_mem;
        logic [BYTE_W-1:0] scr1;
        logic [BYTE_W-1:0] scr3;
        logic [REG_W-1:0]  ptr;
    } cmd_state_t;

    typedef struct packed {
        logic       act;
        logic       err;
        logic       irq;
        logic [1:0] cap;
    } stat_state_t;

endpackage

// File: rtl/bmdma_cmd_path.sv
module bmdma_cmd_path
    import bmdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [LANES-1:0] be,
    input  logic [REG_W-1:0] wdata,
    input  logic             act,
    output logic             start_req,
    output logic             abort_req,
    output logic             cmd_start,
    output logic             cmd_to_mem,
    output logic [BYTE_W-1:0] scr1,
    output logic [BYTE_W-1:0] scr3,
    output logic [REG_W-1:0] ptr
);

    cmd_state_t q, d;
    logic       cmd_hit;
    logic       go_bit;

    always_comb begin
        d         = q;
        cmd_hit   = wr_lo && be[LANE_CMD];
        go_bit    = wdata[LANE_CMD*BYTE_W + CMD_GO];
        start_req = cmd_hit && go_bit && !act;
        abort_req = cmd_hit && !go_bit;

        // A go request while running is dropped as a whole write
        if (cmd_hit && !(go_bit && act)) begin
            d.start  = go_bit;
            d.to_mem = wdata[LANE_CMD*BYTE_W + CMD_DIR];
        end
        if (wr_lo && be[LANE_SCR1]) begin
            d.scr1 = wdata[LANE_SCR1*BYTE_W +: BYTE_W];
        end
        if (wr_lo && be[LANE_SCR3]) begin
            d.scr3 = wdata[LANE_SCR3*BYTE_W +: BYTE_W];
        end
        for (int k = 0; k < LANES; k++) begin
            if (wr_hi && be[k]) begin
                d.ptr[k*BYTE_W +: BYTE_W] = wdata[k*BYTE_W +: BYTE_W];
            end
        end
        d.ptr[ALIGN_W-1:0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_start  = q.start;
    assign cmd_to_mem = q.to_mem;
    assign scr1       = q.scr1;
    assign scr3       = q.scr3;
    assign ptr        = q.ptr;

endmodule

// File: rtl/bmdma_stat_path.sv
module bmdma_stat_path
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       abort_req,
    input  logic       stat_hit,
    input  logic       clr_err,
    input  logic       clr_irq,
    input  logic [1:0] cap_wval,
    input  logic       eng_done,
    input  logic       eng_err,
    output logic       act,
    output logic       err,
    output logic       irq,
    output logic [1:0] cap,
    output logic       good
);

    stat_state_t q, d;

    always_comb begin
        d = q;
        if (start_req) begin
            d.act = 1'b1;
        end
        if (abort_req) begin
            d.act = 1'b0;
        end
        if (stat_hit) begin
            if (clr_err) begin
                d.err = 1'b0;
            end
            if (clr_irq) begin
                d.irq = 1'b0;
            end
            d.cap = cap_wval;
        end
        // Engine events only count while running; they override host clears
        if (q.act && eng_err) begin
            d.err = 1'b1;
            d.irq = 1'b1;
            d.act = 1'b0;
        end else if (q.act && eng_done) begin
            d.irq = 1'b1;
            d.act = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign act  = q.act;
    assign err  = q.err;
    assign irq  = q.irq;
    assign cap  = q.cap;
    assign good = q.irq && !q.err && !q.act;

endmodule

// File: rtl/bmdma_rd_mux.sv
module bmdma_rd_mux
    import bmdma_pkg::*;
(
    input  logic              sel_hi,
    input  logic              cmd_start,
    input  logic              cmd_to_mem,
    input  logic [BYTE_W-1:0] scr1,
    input  logic [BYTE_W-1:0] scr3,
    input  logic              act,
    input  logic              err,
    input  logic              irq,
    input  logic [1:0]        cap,
    input  logic [REG_W-1:0]  ptr,
    output logic [REG_W-1:0]  rdata
);

    logic [BYTE_W-1:0] cmd_byte;
    logic [BYTE_W-1:0] stat_byte;
    logic [REG_W-1:0]  lo_word;

    always_comb begin
        cmd_byte           = '0;
        cmd_byte[CMD_GO]   = cmd_start;
        cmd_byte[CMD_DIR]  = cmd_to_mem;
        stat_byte          = '0;
        stat_byte[ST_ACT]  = act;
        stat_byte[ST_ERR]  = err;
        stat_byte[ST_IRQ]  = irq;
        stat_byte[ST_CAP0] = cap[0];
        stat_byte[ST_CAP1] = cap[1];
        lo_word                               = '0;
        lo_word[LANE_CMD*BYTE_W  +: BYTE_W]   = cmd_byte;
        lo_word[LANE_SCR1*BYTE_W +: BYTE_W]   = scr1;
        lo_word[LANE_STAT*BYTE_W +: BYTE_W]   = stat_byte;
        lo_word[LANE_SCR3*BYTE_W +: BYTE_W]   = scr3;
        rdata = sel_hi ? ptr : lo_word;
    end

endmodule

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
    import bmdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [LANES-1:0] reg_be,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             eng_run,
    output logic             eng_to_mem,
    output logic [REG_W-1:0] eng_table_base,
    input  logic             eng_done,
    input  logic             eng_err,
    output logic             irq,
    output logic             xfer_good
);

    logic              wr_lo, wr_hi;
    logic              start_req, abort_req;
    logic              cmd_start, cmd_to_mem;
    logic [BYTE_W-1:0] scr1, scr3;
    logic [REG_W-1:0]  ptr;
    logic              st_act, st_err, st_irq;
    logic [1:0]        st_cap;
    logic              stat_hit;

    assign wr_lo    = reg_wr && !reg_sel;
    assign wr_hi    = reg_wr && reg_sel;
    assign stat_hit = wr_lo && reg_be[LANE_STAT];

    bmdma_cmd_path u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .be         (reg_be),
        .wdata      (reg_wdata),
        .act        (st_act),
        .start_req  (start_req),
        .abort_req  (abort_req),
        .cmd_start  (cmd_start),
        .cmd_to_mem (cmd_to_mem),
        .scr1       (scr1),
        .scr3       (scr3),
        .ptr        (ptr)
    );

    bmdma_stat_path u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .abort_req (abort_req),
        .stat_hit  (stat_hit),
        .clr_err   (reg_wdata[LANE_STAT*BYTE_W + ST_ERR]),
        .clr_irq   (reg_wdata[LANE_STAT*BYTE_W + ST_IRQ]),
        .cap_wval  ({reg_wdata[LANE_STAT*BYTE_W + ST_CAP1],
                     reg_wdata[LANE_STAT*BYTE_W + ST_CAP0]}),
        .eng_done  (eng_done),
        .eng_err   (eng_err),
        .act       (st_act),
        .err       (st_err),
        .irq       (st_irq),
        .cap       (st_cap),
        .good      (xfer_good)
    );

    bmdma_rd_mux u_rd (
        .sel_hi     (reg_sel),
        .cmd_start  (cmd_start),
        .cmd_to_mem (cmd_to_mem),
        .scr1       (scr1),
        .scr3       (scr3),
        .act        (st_act),
        .err        (st_err),
        .irq        (st_irq),
        .cap        (st_cap),
        .ptr        (ptr),
        .rdata      (reg_rdata)
    );

    assign eng_run        = st_act;
    assign eng_to_mem     = cmd_to_mem;
    assign eng_table_base = ptr;
    assign irq            = st_irq;

endmodule

// File: rtl/bmdma_ctrl_chk.sv
module bmdma_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_cmd,
    input logic       wbit_go,
    input logic       wr_stat,
    input logic       wbit_errclr,
    input logic       rd_hi,
    input logic [1:0] rd_low2,
    input logic       eng_run,
    input logic       eng_done,
    input logic       eng_err,
    input logic       st_err,
    input logic       st_irq,
    input logic [1:0] st_cap
);

    // R2: the channel only becomes active after a go write
    assert_run_needs_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_run) |-> $past(wr_cmd && wbit_go));

    // R4: a stop write always leaves the channel idle
    assert_stop_idles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !wbit_go) |=> !eng_run);

    // R6: completion while running raises the flag and idles the channel
    assert_done_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_run && eng_done && !eng_err) |=> (st_irq && !eng_run));

    // R7: fault while running raises both flags and idles the channel
    assert_fault_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_run && eng_err) |=> (st_err && st_irq && !eng_run));

    // R8: the fault flag is sticky unless cleared by a one
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_err && !(wr_stat && wbit_errclr)) |=> st_err);

    // R9: capability flags move only on a status write
    assert_cap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> $stable(st_cap));

    // R10: table base is always dword aligned when read
    assert_base_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |-> (rd_low2 == 2'b00));

endmodule

bind bmdma_ctrl bmdma_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_cmd      (reg_wr && !reg_sel && reg_be[0]),
    .wbit_go     (reg_wdata[0]),
    .wr_stat     (reg_wr && !reg_sel && reg_be[2]),
    .wbit_errclr (reg_wdata[17]),
    .rd_hi       (reg_sel),
    .rd_low2     (reg_rdata[1:0]),
    .eng_run     (eng_run),
    .eng_done    (eng_done),
    .eng_err     (eng_err),
    .st_err      (st_err),
    .st_irq      (st_irq),
    .st_cap      (st_cap)
);

// File: tb/tb_bmdma_ctrl.sv
`timescale 1ns/1ps
module tb_bmdma_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_run, eng_to_mem, irq, xfer_good;
    logic [31:0] eng_table_base;
    logic        eng_done = 1'b0;
    logic        eng_err = 1'b0;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    bmdma_ctrl dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_sel        (reg_sel),
        .reg_wr         (reg_wr),
        .reg_be         (reg_be),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .eng_run        (eng_run),
        .eng_to_mem     (eng_to_mem),
        .eng_table_base (eng_table_base),
        .eng_done       (eng_done),
        .eng_err        (eng_err),
        .irq            (irq),
        .xfer_good      (xfer_good)
    );

    // {wr, sel, be[3:0], wdata[31:0], done, err, exp_lo[31:0], exp_hi[31:0]}
    localparam int NV = 15;
    localparam logic [103:0] VEC [0:NV-1] = '{
        // R5 R9 R11: direction, caps and scratch; stop write while idle
        {1'b1, 1'b0, 4'b1111, 32'hA560_3C08, 1'b0, 1'b0, 32'hA560_3C08, 32'h0000_0000},
        // R10: base written, low bits forced to zero
        {1'b1, 1'b1, 4'b1111, 32'h1234_567B, 1'b0, 1'b0, 32'hA560_3C08, 32'h1234_5678},
        // R2: go while idle
        {1'b1, 1'b0, 4'b0001, 32'h0000_0009, 1'b0, 1'b0, 32'hA561_3C09, 32'h1234_5678},
        // R3: go while active, new direction dropped
        {1'b1, 1'b0, 4'b0001, 32'h0000_0001, 1'b0, 1'b0, 32'hA561_3C09, 32'h1234_5678},
        // R6 R12 R13: completion
        {1'b0, 1'b0, 4'b0000, 32'h0000_0000, 1'b1, 1'b0, 32'hA564_3C09, 32'h1234_5678},
        // R6: completion while idle ignored
        {1'b0, 1'b0, 4'b0000, 32'h0000_0000, 1'b1, 1'b0, 32'hA564_3C09, 32'h1234_5678},
        // R8: zeros in clear bits keep the flags
        {1'b1, 1'b0, 4'b0100, 32'h0060_0000, 1'b0, 1'b0, 32'hA564_3C09, 32'h1234_5678},
        // R8: one clears the completion flag
        {1'b1, 1'b0, 4'b0100, 32'h0064_0000, 1'b0, 1'b0, 32'hA560_3C09, 32'h1234_5678},
        // R2 R5: go toward device
        {1'b1, 1'b0, 4'b0001, 32'h0000_0001, 1'b0, 1'b0, 32'hA561_3C01, 32'h1234_5678},
        // R7: fault
        {1'b0, 1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b1, 32'hA566_3C01, 32'h1234_5678},
        // R8 R9: clear fault, drop drive 1 cap
        {1'b1, 1'b0, 4'b0100, 32'h0022_0000, 1'b0, 1'b0, 32'hA524_3C01, 32'h1234_5678},
        // R11: scratch lanes only
        {1'b1, 1'b0, 4'b1010, 32'h5A00_C300, 1'b0, 1'b0, 32'h5A24_C301, 32'h1234_5678},
        // R10: single lane base write
        {1'b1, 1'b1, 4'b0001, 32'h0000_00FF, 1'b0, 1'b0, 32'h5A24_C301, 32'h1234_56FC},
        // R2 R6: go with a same-cycle pulse that is still idle
        {1'b1, 1'b0, 4'b0001, 32'h0000_0009, 1'b1, 1'b0, 32'h5A25_C309, 32'h1234_56FC},
        // R4: stop
        {1'b1, 1'b0, 4'b0001, 32'h0000_0000, 1'b0, 1'b0, 32'h5A24_C300, 32'h1234_56FC}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic sel, input logic [3:0] be,
                        input logic [31:0] data, input logic dn, input logic er);
        @(negedge clk);
        reg_wr = wr; reg_sel = sel; reg_be = be; reg_wdata = data;
        eng_done = dn; eng_err = er;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
        eng_done = 1'b0; eng_err = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic stat_check(input string tag, input logic [7:0] exp);
        logic [31:0] v;
        rd(1'b0, v);
        check(tag, {24'h0, v[23:16]}, {24'h0, exp});
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(1'b0, v); check("R1 low dword", v, 32'h0);
        rd(1'b1, v); check("R1 base dword", v, 32'h0);
        check("R1 outputs", {27'h0, irq, eng_run, eng_to_mem, xfer_good, 1'b0}, 32'h0);
        check("R1 base out", eng_table_base, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [103:0] e;
            e = VEC[i];
            step(e[103], e[102], e[101:98], e[97:66], e[65], e[64]);
            rd(1'b0, v); check($sformatf("vec %0d low dword", i), v, e[63:32]);
            rd(1'b1, v); check($sformatf("vec %0d R10 base read", i), v, e[31:0]);
            check($sformatf("vec %0d R10 base out", i), eng_table_base, e[31:0]);
            check($sformatf("vec %0d R12 irq", i), {31'h0, irq}, {31'h0, e[50]});
            check($sformatf("vec %0d R13 good", i), {31'h0, xfer_good},
                  {31'h0, (e[50:48] == 3'b100)});
            check($sformatf("vec %0d R2 run", i), {31'h0, eng_run}, {31'h0, e[48]});
            check($sformatf("vec %0d R5 dir", i), {31'h0, eng_to_mem}, {31'h0, e[35]});
        end

        // R8: engine set beats host clear in the same cycle
        step(1'b1, 1'b0, 4'b0100, 32'h0026_0000, 1'b0, 1'b0);
        stat_check("R8 clear all", 8'h20);
        step(1'b1, 1'b0, 4'b0001, 32'h0000_0001, 1'b0, 1'b0);
        stat_check("R2 start again", 8'h21);
        step(1'b1, 1'b0, 4'b0100, 32'h0026_0000, 1'b1, 1'b0);
        stat_check("R8 set wins", 8'h24);
        check("R12 irq after set wins", {31'h0, irq}, 32'h1);

        // R7: fault and completion together
        step(1'b1, 1'b0, 4'b0100, 32'h0026_0000, 1'b0, 1'b0);
        step(1'b1, 1'b0, 4'b0001, 32'h0000_0001, 1'b0, 1'b0);
        step(1'b0, 1'b0, 4'b0000, 32'h0, 1'b1, 1'b1);
        stat_check("R7 both pulses", 8'h26);
        check("R13 not good after fault", {31'h0, xfer_good}, 32'h0);

        // R4 R6: stop write alongside completion
        step(1'b1, 1'b0, 4'b0100, 32'h0026_0000, 1'b0, 1'b0);
        step(1'b1, 1'b0, 4'b0001, 32'h0000_0001, 1'b0, 1'b0);
        step(1'b1, 1'b0, 4'b0001, 32'h0000_0000, 1'b1, 1'b0);
        stat_check("R4 stop with done", 8'h24);
        check("R13 good after done", {31'h0, xfer_good}, 32'h1);
        check("R4 run low", {31'h0, eng_run}, 32'h0);

        // R1: reset while running
        step(1'b1, 1'b0, 4'b0001, 32'h0000_0009, 1'b0, 1'b0);
        check("R2 run before reset", {31'h0, eng_run}, 32'h1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rd(1'b0, v); check("R1 low after reset", v, 32'h0);
        rd(1'b1, v); check("R1 base after reset", v, 32'h0);
        check("R1 outputs after reset", {28'h0, irq, eng_run, eng_to_mem, xfer_good}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule